// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port

This block is a configurable-width parallel port that a host controls over a small synchronous register bus with a 2-bit word address, a select, and read and write strobes. Each pin has its own direction bit and its own interrupt-enable bit. Each pin drives an output value through an output enable, and its input value can be read back. A single interrupt line tells the host when an enabled pin needs service.

Pin inputs are asynchronous. They pass through a two-stage synchroniser before any logic uses them. Sticky per-pin flags record the transitions chosen at compile time. In the two level modes the interrupt instead follows the live, synchronised pin level. The pad itself is modelled as three separate vectors: driven value, drive enable and sampled input.

Top module: `par_io_port`

## Requirements
- R1: A write at word address 0 loads the output latch, and `pin_out` shows the new value from the cycle after the write.
- R2: Word address 1 holds the direction register. Bit value 1 enables the pin driver (`pin_oe`) and 0 leaves the pin an input. The register can be read back.
- R3: Word address 2 holds the per-pin interrupt enable. It can be read back, and bits above the port width read as zero.
- R4: Word address 3 holds the sticky transition flags. A write at address 3 with any data clears all of them. A transition detected in the same cycle as the clearing write stays recorded.
- R5: The compile-time mode chooses which transition sets a flag: rising only, falling only, or either direction. In the level-high and level-low modes a flag records a move into the selected level.
- R6: In the level modes, `irq` is high while any enabled pin's synchronised input sits at the selected level.
- R7: In the transition modes, `irq` is the OR over all pins of flag AND enable. With no pin enabled, `irq` stays low in every mode.
- R8: A read at word address 0 returns the pin inputs after a two-stage synchroniser. Bits above the port width read as zero.
- R9: Read data is registered. It is valid in the cycle after a selected read and holds its value until the next selected read.
- R10: After reset the output latch, direction, enable and flags are all zero, and so is the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| bus_sel | input | 1 | Select for this port |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Word address: 0 data, 1 direction, 2 enable, 3 flags |
| bus_wdata | input | 32 | Write data; only the low W bits are used |
| bus_rdata | output | 32 | Registered read data, zero-extended |
| pin_in | input | W | Sampled pin levels (asynchronous) |
| pin_out | output | W | Value driven on the pins |
| pin_oe | output | W | Per-pin driver enable |
| irq | output | 1 | Interrupt request |

## Verification
Register writes show on `pin_out`, `pin_oe` and the enable one edge after the write. Read data shows one edge after a selected read. The bench therefore checks direct outputs at the falling edge that follows the write. A scoreboard pops the expected read value at the falling edge after the read is sampled.

A pin change applied before edge e0 reaches the synchronised value at e1. A transition flag or level interrupt reacts by e2 at the latest, so the bench waits four cycles before it looks. The same-cycle clearing case is timed exactly: the clearing write is presented so that the edge which samples it is the same edge that detects the new transition.

// File: rtl/par_io_pkg.sv
package par_io_pkg;

  typedef enum logic [2:0] {
    IRQ_RISE     = 3'd0,
    IRQ_FALL     = 3'd1,
    IRQ_BOTH     = 3'd2,
    IRQ_LVL_HIGH = 3'd3,
    IRQ_LVL_LOW  = 3'd4
  } irq_mode_e;

  localparam int unsigned BUS_DW = 32;
  localparam int unsigned BUS_AW = 2;

  localparam logic [BUS_AW-1:0] A_DATA = 2'd0;
  localparam logic [BUS_AW-1:0] A_DIR  = 2'd1;
  localparam logic [BUS_AW-1:0] A_MASK = 2'd2;
  localparam logic [BUS_AW-1:0] A_FLAG = 2'd3;

endpackage

// File: rtl/par_io_rst_sync.sv
module par_io_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_q_n = stage_q[1];
endmodule

// File: rtl/par_io_sync.sv
module par_io_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;
  logic [W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= async_in;
      safe_q <= meta_q;
    end
  end

  assign sync_out = safe_q;
endmodule

// File: rtl/par_io_edge.sv
module par_io_edge
  import par_io_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter irq_mode_e   IRQ_MODE = IRQ_RISE
) (
  input  logic         clk,
  input  logic         rst_q_n,
  input  logic [W-1:0] lvl_s,
  input  logic [W-1:0] mask_q,
  input  logic         flag_clr,
  output logic [W-1:0] flag_q,
  output logic         irq
);
  logic [W-1:0] prev_q;
  logic [W-1:0] det;
  logic [W-1:0] flag_n;

  always_comb begin
    unique case (IRQ_MODE)
      IRQ_RISE, IRQ_LVL_HIGH: det = lvl_s & ~prev_q;
      IRQ_FALL, IRQ_LVL_LOW:  det = ~lvl_s & prev_q;
      default:                det = lvl_s ^ prev_q;
    endcase
  end

  always_comb begin
    flag_n = flag_clr ? '0 : flag_q;
    flag_n = flag_n | det;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_s;
      flag_q <= flag_n;
    end
  end

  generate
    if (IRQ_MODE == IRQ_LVL_HIGH) begin : g_lvl_hi
      assign irq = |(mask_q & lvl_s);
    end else if (IRQ_MODE == IRQ_LVL_LOW) begin : g_lvl_lo
      assign irq = |(mask_q & ~lvl_s);
    end else begin : g_edge
      assign irq = |(mask_q & flag_q);
    end
  endgenerate
endmodule

// File: rtl/par_io_regs.sv
module par_io_regs
  import par_io_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_q_n,
  input  logic              sel,
  input  logic              rd,
  input  logic              wr,
  input  logic [BUS_AW-1:0] addr,
  input  logic [BUS_DW-1:0] wdata,
  input  logic [W-1:0]      lvl_s,
  input  logic [W-1:0]      flag_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mask_q,
  output logic              flag_clr,
  output logic [BUS_DW-1:0] rdata
);
  logic              wr_en;
  logic              rd_en;
  logic [W-1:0]      out_n;
  logic [W-1:0]      dir_n;
  logic [W-1:0]      mask_n;
  logic [BUS_DW-1:0] rd_n;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;
  assign wr_en    = sel & wr;
  assign rd_en    = sel & rd;
  assign flag_clr = wr_en && (addr == A_FLAG);

  always_comb begin
    out_n  = out_q;
    dir_n  = dir_q;
    mask_n = mask_q;
    if (wr_en) begin
      unique case (addr)
        A_DATA:  out_n  = wdata[W-1:0];
        A_DIR:   dir_n  = wdata[W-1:0];
        A_MASK:  mask_n = wdata[W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    unique case (addr)
      A_DATA:  rd_n[W-1:0] = lvl_s;
      A_DIR:   rd_n[W-1:0] = dir_q;
      A_MASK:  rd_n[W-1:0] = mask_q;
      default: rd_n[W-1:0] = flag_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
      rdata  <= '0;
    end else begin
      out_q  <= out_n;
      dir_q  <= dir_n;
      mask_q <= mask_n;
      if (rd_en) rdata <= rd_n;
    end
  end
endmodule

// File: rtl/par_io_port.sv
module par_io_port
  import par_io_pkg::*;
#(
  parameter int unsigned W        = 8,
  parameter irq_mode_e   IRQ_MODE = IRQ_RISE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_rd,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [31:0]  bus_wdata,
  output logic [31:0]  bus_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         irq
);
  logic         rst_q_n;
  logic [W-1:0] lvl_s;
  logic [W-1:0] mask_q;
  logic [W-1:0] cap_q;
  logic         flag_clr;

  par_io_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  par_io_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .async_in (pin_in),
    .sync_out (lvl_s)
  );

  par_io_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .sel      (bus_sel),
    .rd       (bus_rd),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .lvl_s    (lvl_s),
    .flag_q   (cap_q),
    .out_q    (pin_out),
    .dir_q    (pin_oe),
    .mask_q   (mask_q),
    .flag_clr (flag_clr),
    .rdata    (bus_rdata)
  );

  par_io_edge #(.W(W), .IRQ_MODE(IRQ_MODE)) u_edge (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .lvl_s    (lvl_s),
    .mask_q   (mask_q),
    .flag_clr (flag_clr),
    .flag_q   (cap_q),
    .irq      (irq)
  );
endmodule

// File: rtl/par_io_chk.sv
module par_io_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_q_n,
  input logic         sel,
  input logic         rd,
  input logic         wr,
  input logic [1:0]   addr,
  input logic [31:0]  wdata,
  input logic [31:0]  rdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] cap_q,
  input logic         irq
);
  p_out_load_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel && wr && addr == 2'd0) |=> (pin_out == $past(wdata[W-1:0])));

  p_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel && wr && addr == 2'd1) |=> (pin_oe == $past(wdata[W-1:0])));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (sel && wr && addr == 2'd2) |=> (mask_q == $past(wdata[W-1:0])));

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(sel && wr && addr == 2'd3) |=> (($past(cap_q) & ~cap_q) == '0));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mask_q == '0) |-> !irq);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(sel && rd) |=> $stable(rdata));
endmodule

bind par_io_port par_io_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .sel     (bus_sel),
  .rd      (bus_rd),
  .wr      (bus_wr),
  .addr    (bus_addr),
  .wdata   (bus_wdata),
  .rdata   (bus_rdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .mask_q  (mask_q),
  .cap_q   (cap_q),
  .irq     (irq)
);

// File: tb/par_io_port_bench.sv
`timescale 1ns/1ps
module par_io_port_bench;
  import par_io_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [7:0]  pins = '0;

  logic [31:0] rd_m, rd_b, rd_l;
  logic [7:0]  out_m, oe_m, out_b, oe_b;
  logic [4:0]  out_l, oe_l;
  logic        irq_m, irq_b, irq_l;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  par_io_port #(.W(8), .IRQ_MODE(IRQ_RISE)) u_par_io_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_m),
    .pin_in(pins), .pin_out(out_m), .pin_oe(oe_m), .irq(irq_m));

  par_io_port #(.W(8), .IRQ_MODE(IRQ_BOTH)) u_par_io_port_both (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_b),
    .pin_in(pins), .pin_out(out_b), .pin_oe(oe_b), .irq(irq_b));

  par_io_port #(.W(5), .IRQ_MODE(IRQ_LVL_LOW)) u_par_io_port_lvl (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_rd(rd), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_l),
    .pin_in(pins[4:0]), .pin_out(out_l), .pin_oe(oe_l), .irq(irq_l));

  int          q_dut[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic        rd_seen = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= sel && rd;

  always @(negedge clk) begin
    if (rd_seen && q_exp.size() > 0) begin
      int          d;
      logic [31:0] e;
      string       t;
      d = q_dut.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      case (d)
        0:       chk(t, rd_m, e);
        1:       chk(t, rd_b, e);
        default: chk(t, rd_l, e);
      endcase
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, input int dut,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = a;
    q_dut.push_back(dut);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R10: reset state
    chk("R10 pin_out", {24'd0, out_m}, 32'd0);
    chk("R10 pin_oe", {24'd0, oe_m}, 32'd0);
    chk("R10 irq", {31'd0, irq_m}, 32'd0);
    chk("R10 lvl irq", {31'd0, irq_l}, 32'd0);
    bus_read(2'd0, 0, 32'd0, "R10 data");
    bus_read(2'd1, 0, 32'd0, "R10 dir");
    bus_read(2'd2, 0, 32'd0, "R10 mask");
    bus_read(2'd3, 0, 32'd0, "R10 flags");

    // R1: output latch
    bus_write(2'd0, 32'h0000_00A5);
    chk("R1 pin_out", {24'd0, out_m}, 32'h0000_00A5);
    bus_write(2'd0, 32'h0000_005A);
    chk("R1 pin_out second", {24'd0, out_m}, 32'h0000_005A);

    // R2: direction
    bus_write(2'd1, 32'h0000_000F);
    chk("R2 pin_oe", {24'd0, oe_m}, 32'h0000_000F);
    bus_read(2'd1, 0, 32'h0000_000F, "R2 dir readback");

    // R3: mask, upper bits zero; R6: level-low irq with pins low
    bus_write(2'd2, 32'hFFFF_FF3C);
    bus_read(2'd2, 0, 32'h0000_003C, "R3 mask readback");
    bus_read(2'd2, 2, 32'h0000_001C, "R3 mask narrow port");
    chk("R6 lvl irq pins low", {31'd0, irq_l}, 32'd1);

    // R8, R5, R7: rising transitions on bits 0 and 7
    @(negedge clk); pins = 8'h81;
    idle(4);
    bus_read(2'd0, 0, 32'h0000_0081, "R8 data readback");
    bus_read(2'd3, 0, 32'h0000_0081, "R5 rise flags");
    bus_read(2'd3, 1, 32'h0000_0081, "R5 both flags rise");
    chk("R7 irq masked off", {31'd0, irq_m}, 32'd0);

    // R4 clear, R5 falling on bit 7
    bus_write(2'd3, 32'h0000_DEAD);
    bus_read(2'd3, 0, 32'd0, "R4 flags cleared");
    @(negedge clk); pins = 8'h01;
    idle(4);
    bus_read(2'd3, 0, 32'd0, "R5 rise ignores fall");
    bus_read(2'd3, 1, 32'h0000_0080, "R5 both sees fall");

    // R7: enabled flag drives irq, clear drops it
    @(negedge clk); pins = 8'h05;
    idle(4);
    chk("R7 irq enabled flag", {31'd0, irq_m}, 32'd1);
    bus_read(2'd3, 0, 32'h0000_0004, "R7 flag bit2");
    bus_write(2'd3, 32'd0);
    chk("R4 irq after clear", {31'd0, irq_m}, 32'd0);

    // R4: transition detected on the clearing edge survives
    @(negedge clk); pins = 8'h0D;
    idle(4);
    bus_read(2'd3, 0, 32'h0000_0008, "R4 flag bit3 set");
    @(negedge clk); pins = 8'h2D;
    @(negedge clk);
    bus_write(2'd3, 32'hFFFF_FFFF);
    bus_read(2'd3, 0, 32'h0000_0020, "R4 same-cycle survives");

    // R9: read data holds without a read
    idle(3);
    bus_write(2'd2, 32'h0000_003C);
    idle(2);
    chk("R9 rdata holds", rd_m, 32'h0000_0020);

    // R6: level-low, enabled bits 2..4
    @(negedge clk); pins = 8'h1D;
    idle(4);
    chk("R6 lvl irq all high", {31'd0, irq_l}, 32'd0);
    bus_read(2'd0, 2, 32'h0000_001D, "R8 narrow data readback");
    @(negedge clk); pins = 8'h15;
    idle(4);
    chk("R6 lvl irq bit3 low", {31'd0, irq_l}, 32'd1);

    idle(3);
    finish_run();
  end
endmodule